// File: doc/BRIEF.md
# Display Frame Descriptor Fetcher

This block serves one display DMA channel. On each frame-start pulse it chooses where the next frame descriptor lives and reads that descriptor from memory. It then presents the descriptor's contents as registers and signals the frame events to an interrupt block. A descriptor is four 32-bit words at consecutive word addresses. The words hold, in order, the link to the following descriptor, the frame source address, a frame identifier and a command word. Each word is taken exactly as it arrives, least significant byte in the low bits, with no swapping.

Normally the fetcher follows the linked list through the stored pointer. A branch register can redirect one fetch to another descriptor. That fetch consumes the branch request and can optionally report a branch event. Every descriptor address and every source address is checked against a set of allowed memory windows before it is used. A failed check produces a bus-error event instead of a frame. Pixel fetching and interrupt merging belong to other blocks. The pixel fetcher is started with `frame_go_o` and reports back with `frame_done_i`.

Top module: `frame_desc_fetch`

## Requirements
- R1: After reset all register outputs read zero, no memory request is made, `busy_o` is low and no event output is high.
- R2: A write with `cfg_sel_i`=0 loads the descriptor pointer with bits 3:0 forced to zero. A write with `cfg_sel_i`=1 loads the branch register, keeping bits 31:4 and 1:0 and clearing bits 3:2.
- R3: A frame start without a branch request reads the four words at the pointer, pointer+4, pointer+8 and pointer+12, in that order, one read outstanding at a time. The words go to `desc_ptr_o`, `src_addr_o`, `frame_id_o` and `cmd_o` respectively.
- R4: When branch bit 0 is set at a frame start, the fetch uses branch bits 31:4 with four zero low bits as the descriptor address. Branch bit 0 is then cleared and the other branch bits are kept.
- R5: `bs_o` pulses for one cycle, in the cycle after the frame-start edge, exactly when branch bits 0 and 1 were both set at that start.
- R6: If the descriptor address plus 16 bytes does not fit wholly inside one allowed window, no memory read is made. In that case `src_addr_o` reads zero and `berr_o` pulses in the second cycle after the frame-start edge.
- R7: After a fetch, a source address of zero, or one beyond the end of every window, causes a `berr_o` pulse with no `frame_go_o` and no `sof_o`.
- R8: A command word with bit 26 (palette) set gives a one-cycle `pal_load_o` pulse and no `sof_o`, `frame_go_o` or `eof_o`.
- R9: For a normal frame, `frame_go_o` pulses once after the fetch, and `sof_o` pulses with it only if command bit 22 is set. A later `frame_done_i` returns the block to idle and pulses `eof_o` only if command bit 21 is set.
- R10: A frame-start pulse is ignored while `en_i` is low or while `busy_o` is high. No request is made and no register changes.
- R11: A new memory request is never raised while an accepted read still awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| frame_start_i | input | 1 | One-cycle frame-start pulse |
| frame_done_i | input | 1 | Pixel fetcher reports frame complete |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = descriptor pointer, 1 = branch register |
| cfg_wdata_i | input | 32 | Register write data |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| desc_ptr_o | output | 32 | Next descriptor pointer |
| src_addr_o | output | 32 | Frame source address |
| frame_id_o | output | 32 | Frame identifier |
| cmd_o | output | 32 | Command word (length bits 20:2, flags 21, 22, 26) |
| branch_o | output | 32 | Branch register |
| busy_o | output | 1 | Fetch or frame in progress |
| sof_o | output | 1 | Start-of-frame event |
| eof_o | output | 1 | End-of-frame event |
| bs_o | output | 1 | Branch-status event |
| berr_o | output | 1 | Bus-error event |
| pal_load_o | output | 1 | Palette-load frame started |
| frame_go_o | output | 1 | Start pixel fetch for this frame |

## Verification
All event outputs are registered. `bs_o` is visible in the first cycle after the frame-start edge. A skipped fetch shows `berr_o` one cycle later. With a memory that answers one cycle after accepting a request, a full fetch puts its events in the cycle after the ninth edge following the start, and `eof_o` appears in the cycle after the `frame_done_i` edge. The bench drives inputs on falling edges and counts falling edges from each stimulus to the exact cycle a result is due. It samples there, so a pulse that is late or early by one cycle fails its check.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned DESC_BYTES = DESC_WORDS * WORD_W / 8;

  localparam logic [WORD_W-1:0] BRA_KEEP = 32'hFFFF_FFF3;
  localparam int unsigned BRA_REQ = 0;
  localparam int unsigned BRA_INT = 1;
  localparam int unsigned ALIGN_W = 4;

  localparam int unsigned CMD_EOF = 21;
  localparam int unsigned CMD_SOF = 22;
  localparam int unsigned CMD_PAL = 26;

  localparam logic CFG_PTR = 1'b0;
  localparam logic CFG_BRA = 1'b1;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_EVAL, S_RUN
  } seq_state_e;

  typedef struct packed {
    logic sof;
    logic eof;
    logic bs;
    logic berr;
    logic pal;
    logic go;
  } fdf_events_t;
endpackage

// File: rtl/fdf_win_check.sv
module fdf_win_check #(
  parameter int unsigned NWIN = 2,
  parameter logic [NWIN-1:0][31:0] WIN_BASE = '0,
  parameter logic [NWIN-1:0][31:0] WIN_SIZE = '0,
  parameter int unsigned SPAN = 0
) (
  input  logic [31:0] addr_i,
  output logic        ok_o
);
  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [32:0] lo, hi, top;
    assign lo = {1'b0, WIN_BASE[w]};
    assign hi = {1'b0, WIN_BASE[w]} + {1'b0, WIN_SIZE[w]};
    assign top = {1'b0, addr_i} + 33'(SPAN);
    assign hit[w] = ({1'b0, addr_i} >= lo) && (top <= hi);
  end

  assign ok_o = |hit;
endmodule

// File: rtl/fdf_regs.sv
module fdf_regs
  import fdf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              ld_we_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic              src_clr_i,
  input  logic              bra_clr_i,
  output logic [WORD_W-1:0] ptr_o,
  output logic [WORD_W-1:0] bra_o,
  output logic [WORD_W-1:0] src_o,
  output logic [WORD_W-1:0] id_o,
  output logic [WORD_W-1:0] cmd_o
);
  logic [WORD_W-1:0] ptr_q, bra_q;
  logic [WORD_W-1:0] word_q [1:DESC_WORDS-1];

  // internal updates take priority over a same-cycle config write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ld_we_i && ld_idx_i == '0) begin
      ptr_q <= ld_data_i;
    end else if (cfg_we_i && cfg_sel_i == CFG_PTR) begin
      ptr_q <= {cfg_wdata_i[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bra_q <= '0;
    end else if (bra_clr_i) begin
      bra_q[BRA_REQ] <= 1'b0;
    end else if (cfg_we_i && cfg_sel_i == CFG_BRA) begin
      bra_q <= cfg_wdata_i & BRA_KEEP;
    end
  end

  for (genvar k = 1; k < DESC_WORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[k] <= '0;
      end else if (k == 1 && src_clr_i) begin
        word_q[k] <= '0;
      end else if (ld_we_i && ld_idx_i == IDX_W'(k)) begin
        word_q[k] <= ld_data_i;
      end
    end
  end

  assign ptr_o = ptr_q;
  assign bra_o = bra_q;
  assign src_o = word_q[1];
  assign id_o  = word_q[2];
  assign cmd_o = word_q[3];
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              frame_start_i,
  input  logic              frame_done_i,
  input  logic [WORD_W-1:0] ptr_i,
  input  logic [WORD_W-1:0] bra_addr_i,
  input  logic              bra_req_i,
  input  logic              bra_int_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic              cmd_sof_i,
  input  logic              cmd_eof_i,
  input  logic              cmd_pal_i,
  input  logic              desc_ok_i,
  input  logic              src_ok_i,
  output logic [WORD_W-1:0] cand_addr_o,
  output logic              mem_req_valid_o,
  output logic [WORD_W-1:0] mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  output logic              ld_we_o,
  output logic [IDX_W-1:0]  ld_idx_o,
  output logic              src_clr_o,
  output logic              bra_clr_o,
  output logic              busy_o,
  output fdf_events_t       ev_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  fdf_events_t       ev_q, ev_d;

  assign cand_addr_o = bra_req_i ? bra_addr_i : ptr_i;

  always_comb begin
    state_d   = state_q;
    base_d    = base_q;
    idx_d     = idx_q;
    ev_d      = '0;
    src_clr_o = 1'b0;
    bra_clr_o = 1'b0;
    ld_we_o   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (frame_start_i && en_i) begin
          src_clr_o = 1'b1;
          bra_clr_o = bra_req_i;
          ev_d.bs   = bra_req_i && bra_int_i;
          base_d    = cand_addr_o;
          idx_d     = '0;
          state_d   = desc_ok_i ? S_REQ : S_EVAL;
        end
      end
      S_REQ: begin
        if (mem_req_ready_i) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (mem_rsp_valid_i) begin
          ld_we_o = 1'b1;
          if (idx_q == LAST_IDX) begin
            state_d = S_EVAL;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_REQ;
          end
        end
      end
      S_EVAL: begin
        if (src_i == '0 || !src_ok_i) begin
          ev_d.berr = 1'b1;
          state_d   = S_IDLE;
        end else if (cmd_pal_i) begin
          ev_d.pal = 1'b1;
          state_d  = S_IDLE;
        end else begin
          ev_d.sof = cmd_sof_i;
          ev_d.go  = 1'b1;
          state_d  = S_RUN;
        end
      end
      S_RUN: begin
        if (!en_i) begin
          state_d = S_IDLE;
        end else if (frame_done_i) begin
          ev_d.eof = cmd_eof_i;
          state_d  = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      ev_q    <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
      ev_q    <= ev_d;
    end
  end

  assign mem_req_valid_o = (state_q == S_REQ);
  assign mem_req_addr_o  = base_q + (WORD_W'(idx_q) << 2);
  assign ld_idx_o        = idx_q;
  assign busy_o          = (state_q != S_IDLE);
  assign ev_o            = ev_q;
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch
  import fdf_pkg::*;
#(
  parameter int unsigned NWIN = 2,
  parameter logic [NWIN-1:0][31:0] WIN_BASE = {32'hA000_0000, 32'h5C00_0000},
  parameter logic [NWIN-1:0][31:0] WIN_SIZE = {32'h0400_0000, 32'h0004_0000}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        frame_start_i,
  input  logic        frame_done_i,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  output logic [31:0] desc_ptr_o,
  output logic [31:0] src_addr_o,
  output logic [31:0] frame_id_o,
  output logic [31:0] cmd_o,
  output logic [31:0] branch_o,
  output logic        busy_o,
  output logic        sof_o,
  output logic        eof_o,
  output logic        bs_o,
  output logic        berr_o,
  output logic        pal_load_o,
  output logic        frame_go_o
);
  logic [WORD_W-1:0] cand_addr;
  logic              desc_ok, src_ok;
  logic              ld_we, src_clr, bra_clr;
  logic [IDX_W-1:0]  ld_idx;
  fdf_events_t       ev;

  fdf_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .ld_we_i     (ld_we),
    .ld_idx_i    (ld_idx),
    .ld_data_i   (mem_rsp_data_i),
    .src_clr_i   (src_clr),
    .bra_clr_i   (bra_clr),
    .ptr_o       (desc_ptr_o),
    .bra_o       (branch_o),
    .src_o       (src_addr_o),
    .id_o        (frame_id_o),
    .cmd_o       (cmd_o)
  );

  // descriptor must fit whole; source start may sit at the window end
  fdf_win_check #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
                  .SPAN(DESC_BYTES)) u_desc_win (
    .addr_i (cand_addr),
    .ok_o   (desc_ok)
  );

  fdf_win_check #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
                  .SPAN(0)) u_src_win (
    .addr_i (src_addr_o),
    .ok_o   (src_ok)
  );

  fdf_seq u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_i            (en_i),
    .frame_start_i   (frame_start_i),
    .frame_done_i    (frame_done_i),
    .ptr_i           (desc_ptr_o),
    .bra_addr_i      ({branch_o[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}}),
    .bra_req_i       (branch_o[BRA_REQ]),
    .bra_int_i       (branch_o[BRA_INT]),
    .src_i           (src_addr_o),
    .cmd_sof_i       (cmd_o[CMD_SOF]),
    .cmd_eof_i       (cmd_o[CMD_EOF]),
    .cmd_pal_i       (cmd_o[CMD_PAL]),
    .desc_ok_i       (desc_ok),
    .src_ok_i        (src_ok),
    .cand_addr_o     (cand_addr),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .ld_we_o         (ld_we),
    .ld_idx_o        (ld_idx),
    .src_clr_o       (src_clr),
    .bra_clr_o       (bra_clr),
    .busy_o          (busy_o),
    .ev_o            (ev)
  );

  assign sof_o      = ev.sof;
  assign eof_o      = ev.eof;
  assign bs_o       = ev.bs;
  assign berr_o     = ev.berr;
  assign pal_load_o = ev.pal;
  assign frame_go_o = ev.go;
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       frame_start_i,
  input logic       cfg_we_i,
  input logic       cfg_sel_i,
  input logic       mem_req_valid_o,
  input logic       mem_req_ready_i,
  input logic       mem_rsp_valid_i,
  input logic [3:0] ptr_low_i,
  input logic       bra_req_i,
  input logic       busy_o,
  input logic       sof_o,
  input logic       eof_o,
  input logic       bs_o,
  input logic       berr_o,
  input logic       pal_load_o,
  input logic       frame_go_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) pend_q <= 1'b1;
    else if (mem_rsp_valid_i) pend_q <= 1'b0;
  end

  a_r11_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mem_req_valid_o);

  a_r5_bs_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_o |-> $past(frame_start_i && en_i && !busy_o));

  a_r4_branch_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_o |-> !bra_req_i);

  a_r8_pal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_load_o |-> !(sof_o || frame_go_o || eof_o));

  a_r9_sof_with_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> frame_go_o);

  a_r7_berr_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> !(frame_go_o || sof_o));

  a_r2_ptr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_sel_i && !busy_o) |=> (ptr_low_i == 4'd0));

  a_r10_no_req_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(frame_start_i && en_i)) |=> !mem_req_valid_o);
endmodule

bind frame_desc_fetch fdf_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .frame_start_i   (frame_start_i),
  .cfg_we_i        (cfg_we_i),
  .cfg_sel_i       (cfg_sel_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .ptr_low_i       (desc_ptr_o[3:0]),
  .bra_req_i       (branch_o[0]),
  .busy_o          (busy_o),
  .sof_o           (sof_o),
  .eof_o           (eof_o),
  .bs_o            (bs_o),
  .berr_o          (berr_o),
  .pal_load_o      (pal_load_o),
  .frame_go_o      (frame_go_o)
);

// File: tb/frame_desc_fetch_tb.sv
`timescale 1ns/1ps
module frame_desc_fetch_tb;
  localparam logic [31:0] MBASE = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, fs = 1'b0, done = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [31:0] ptr, src, fid, cmd, bra;
  logic        busy, sof, eof, bs, berr, pal, go;

  int total = 0, bad = 0;
  int req_cnt = 0;
  logic [31:0] req_log [0:63];
  logic [31:0] mem [0:63];

  assign req_ready = 1'b1;

  always #4 clk = ~clk;

  frame_desc_fetch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frame_start_i(fs),
    .frame_done_i(done), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .mem_req_valid_o(req_valid),
    .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .desc_ptr_o(ptr), .src_addr_o(src), .frame_id_o(fid), .cmd_o(cmd),
    .branch_o(bra), .busy_o(busy), .sof_o(sof), .eof_o(eof), .bs_o(bs),
    .berr_o(berr), .pal_load_o(pal), .frame_go_o(go)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (a >= MBASE && a < MBASE + 32'h100) return mem[(a - MBASE) >> 2];
    return 32'hBAD0_0000 | {16'h0, a[15:0]};
  endfunction

  // memory model: answers one cycle after accepting a request
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd(req_addr);
      if (req_cnt < 64) req_log[req_cnt] <= req_addr;
      req_cnt <= req_cnt + 1;
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic put_desc(input int off, input logic [31:0] w0, w1, w2, w3);
    mem[off/4]     = w0;
    mem[off/4 + 1] = w1;
    mem[off/4 + 2] = w2;
    mem[off/4 + 3] = w3;
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns at the falling edge after the sampling edge
  task automatic pulse_start();
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "desc_ptr", ptr, 0);
    chk("R1", "src", src, 0);
    chk("R1", "id", fid, 0);
    chk("R1", "cmd", cmd, 0);
    chk("R1", "branch", bra, 0);
    chk("R1", "busy/req", {30'd0, busy, req_valid}, 0);
    chk("R1", "events", {26'd0, sof, eof, bs, berr, pal, go}, 0);
  endtask

  task automatic t_masks();
    cfg_write(1'b0, 32'hA000_004F);
    chk("R2", "pointer low bits cleared", ptr, 32'hA000_0040);
    cfg_write(1'b1, 32'hFFFF_FFFF);
    chk("R2", "branch bits 3:2 cleared", bra, 32'hFFFF_FFF3);
    cfg_write(1'b1, 32'h0);
    chk("R2", "branch rewrite", bra, 32'h0);
  endtask

  task automatic t_linear();
    int b;
    b = req_cnt;
    pulse_start();
    chk("R5", "no bs without branch", {31'd0, bs}, 0);
    chk("R3", "busy during fetch", {31'd0, busy}, 1);
    repeat (9) @(negedge clk);
    chk("R9", "sof with enable", {31'd0, sof}, 1);
    chk("R9", "frame_go", {31'd0, go}, 1);
    chk("R3", "next ptr word", ptr, 32'hA000_0080);
    chk("R3", "source word", src, 32'hA000_1000);
    chk("R3", "id word", fid, 32'h1234_5678);
    chk("R3", "cmd word", cmd, 32'h0060_0100);
    for (int k = 0; k < 4; k++)
      chk("R3", "read address order", req_log[b + k], 32'hA000_0040 + 32'(4 * k));
    chk("R3", "read count", 32'(req_cnt - b), 4);
    pulse_done();
    chk("R9", "eof with enable", {31'd0, eof}, 1);
    chk("R9", "idle after done", {31'd0, busy}, 0);
  endtask

  task automatic t_chain_and_busy_ignore();
    int b;
    pulse_start();
    repeat (9) @(negedge clk);
    chk("R9", "no sof when bit 22 clear", {31'd0, sof}, 0);
    chk("R9", "frame_go chained", {31'd0, go}, 1);
    chk("R3", "followed link", src, 32'hA000_2000);
    b = req_cnt;
    pulse_start();
    @(negedge clk);
    chk("R10", "start while busy: no read", 32'(req_cnt - b), 0);
    chk("R10", "start while busy: ptr kept", ptr, 32'hA000_0040);
    chk("R10", "start while busy: still busy", {31'd0, busy}, 1);
    pulse_done();
    chk("R9", "no eof when bit 21 clear", {31'd0, eof}, 0);
  endtask

  task automatic t_disabled_ignore();
    int b;
    b = req_cnt;
    en = 1'b0;
    pulse_start();
    repeat (2) @(negedge clk);
    chk("R10", "disabled: not busy", {31'd0, busy}, 0);
    chk("R10", "disabled: no read", 32'(req_cnt - b), 0);
    chk("R10", "disabled: src kept", src, 32'hA000_2000);
    en = 1'b1;
  endtask

  task automatic t_branch();
    int b;
    cfg_write(1'b1, 32'hA000_00C3);
    b = req_cnt;
    pulse_start();
    chk("R5", "bs with request and int", {31'd0, bs}, 1);
    chk("R4", "branch request cleared", bra, 32'hA000_00C2);
    repeat (9) @(negedge clk);
    chk("R4", "fetched from branch", req_log[b], 32'hA000_00C0);
    chk("R4", "branch id", fid, 32'h3);
    chk("R8", "palette pulse", {31'd0, pal}, 1);
    chk("R8", "palette quiet", {30'd0, sof, go}, 0);
    chk("R8", "palette back to idle", {31'd0, busy}, 0);
    chk("R4", "pointer from branch desc", ptr, 32'hA000_0040);
    cfg_write(1'b1, 32'hA000_0081);
    pulse_start();
    chk("R5", "no bs without int bit", {31'd0, bs}, 0);
    chk("R4", "branch cleared again", bra, 32'hA000_0080);
    repeat (9) @(negedge clk);
    chk("R4", "branch frame go", {31'd0, go}, 1);
    chk("R4", "branch src", src, 32'hA000_2000);
    pulse_done();
  endtask

  task automatic t_bad_src();
    cfg_write(1'b0, 32'hA000_00D0);
    pulse_start();
    repeat (9) @(negedge clk);
    chk("R7", "zero source berr", {31'd0, berr}, 1);
    chk("R7", "zero source no go/sof", {30'd0, go, sof}, 0);
    cfg_write(1'b0, 32'hA000_00F0);
    pulse_start();
    repeat (9) @(negedge clk);
    chk("R7", "outside source berr", {31'd0, berr}, 1);
    chk("R7", "outside source no go", {31'd0, go}, 0);
    chk("R7", "idle after berr", {31'd0, busy}, 0);
  endtask

  task automatic t_bad_desc();
    int b;
    cfg_write(1'b0, 32'hA000_00E0);
    pulse_start();
    repeat (9) @(negedge clk);
    chk("R3", "unaligned link fetched", ptr, 32'hA3FF_FFF8);
    pulse_done();
    b = req_cnt;
    pulse_start();
    chk("R6", "straddle: no berr yet", {31'd0, berr}, 0);
    chk("R6", "straddle: src cleared", src, 0);
    @(negedge clk);
    chk("R6", "straddle: berr", {31'd0, berr}, 1);
    chk("R6", "straddle: no read", 32'(req_cnt - b), 0);
    cfg_write(1'b0, 32'h1000_0000);
    b = req_cnt;
    pulse_start();
    @(negedge clk);
    chk("R6", "outside: berr", {31'd0, berr}, 1);
    chk("R6", "outside: no read", 32'(req_cnt - b), 0);
    chk("R6", "outside: src zero", src, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put_desc(32'h40, 32'hA000_0080, 32'hA000_1000, 32'h1234_5678, 32'h0060_0100);
    put_desc(32'h80, 32'hA000_0040, 32'hA000_2000, 32'h2, 32'h0);
    put_desc(32'hC0, 32'hA000_0040, 32'hA000_3000, 32'h3, 32'h0400_0040);
    put_desc(32'hD0, 32'hA000_0040, 32'h0, 32'h4, 32'h0040_0000);
    put_desc(32'hE0, 32'hA3FF_FFF8, 32'hA000_1000, 32'h5, 32'h0);
    put_desc(32'hF0, 32'hA000_0040, 32'h1000_0000, 32'h6, 32'h0040_0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_linear();
    t_chain_and_busy_ignore();
    t_disabled_ignore();
    t_branch();
    t_bad_src();
    t_bad_desc();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule